// File: doc/BRIEF.md
# TDD Burst Direction and Enable Sequencer

This block sits on the baseband side of a radio transceiver's control link. It drives two lines: a pulsed enable line and a direction level. A burst starts when the transceiver sees the enable line high. The direction level sampled at that moment selects transmit (high) or receive (low). A second enable pulse ends the burst. Host logic asks for a burst with `req_start_i` and a direction bit, and later ends it with `req_stop_i`. The sequencer then does four things in order:
- sets the direction first, a programmable number of cycles ahead of the start pulse;
- issues the start pulse;
- holds the direction for the whole burst;
- issues the finish pulse, then keeps the direction for a programmable release window.

The direction line switches synthesizers on and off at the far end, so it may only move while the local model of the transceiver is in its alert state, never during a burst. A request that would move it too early is held back. A mode input picks one of three uses of the direction pin:
- time-division duplex, where the pin carries the burst direction;
- plain frequency-division duplex, where the pin is ignored but parked low;
- independent frequency-division control, where the pin becomes a direct transmit-on level taken from `tx_on_i`.

Top module: `burst_dir_seq`

## Requirements
- R1: After reset, `enable_o`, `txnrx_o`, `busy_o`, `burst_active_o`, `err_start_o` and `err_stop_o` are all 0.
- R2: Mode encoding for `mode_i`: 0 = TDD, 1 = plain FDD, 2 = independent FDD, 3 = same as plain FDD. In TDD mode, the edge that accepts an idle start request loads `req_dir_i` into `txnrx_o`. The start pulse on `enable_o` then appears exactly `setup_cyc_i` cycles later. With a setup of 0, it appears in the same cycle as the new direction.
- R3: In TDD mode, `txnrx_o` never changes while `burst_active_o` was high in the cycle before. It therefore holds one level from the start pulse until the burst ends.
- R4: A `req_stop_i` during a burst produces a one-cycle finish pulse on `enable_o` on the next edge. If the stop arrives in the start-pulse cycle itself, the finish pulse comes one cycle later.
- R5: After a finish pulse, `txnrx_o` keeps its level for `release_cyc_i` further cycles. A start request that arrives inside that window is stored and served once the window has closed.
- R6: `busy_o` is high from the cycle after a start is accepted up to the last cycle before the finish pulse. `burst_active_o` rises together with the start pulse and falls together with the finish pulse.
- R7: A start request while a burst is being set up or is active is ignored and sets `err_start_o`. This flag stays set until reset.
- R8: A stop request while no burst is set up or active sets `err_stop_o`, which stays set until reset, and produces no pulse.
- R9: In plain FDD mode, `txnrx_o` is driven low and stays low, while bursts still produce start and finish pulses.
- R10: In independent FDD mode, `txnrx_o` equals `tx_on_i` from the previous cycle, at any time including during a burst. `req_dir_i` has no effect.
- R11: A change on `mode_i` takes effect only while the sequencer is idle. A change made during a burst applies after the burst has returned to idle.
- R12: `enable_o` is never high on two consecutive cycles. With a setup of 0, a start request made during the finish-pulse cycle is delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Pin usage mode (0 TDD, 1 FDD, 2 independent FDD, 3 as FDD) |
| req_start_i | input | 1 | Start-burst request, one cycle per request |
| req_dir_i | input | 1 | Requested direction, 1 transmit, 0 receive |
| req_stop_i | input | 1 | Finish-burst request, one cycle per request |
| tx_on_i | input | 1 | Transmit-on level used in independent FDD mode |
| setup_cyc_i | input | CNT_W | Cycles from direction setup to start pulse |
| release_cyc_i | input | CNT_W | Cycles the direction is kept after the finish pulse |
| enable_o | output | 1 | Start/finish pulse line to the transceiver |
| txnrx_o | output | 1 | Direction / transmit-on line to the transceiver |
| busy_o | output | 1 | Burst being set up or running |
| burst_active_o | output | 1 | Local transceiver model is in its burst state |
| err_start_o | output | 1 | Sticky flag: start request rejected |
| err_stop_o | output | 1 | Sticky flag: stop request with no burst |

## Verification
The hardest situation to reach is a start request that lands while the direction is still frozen after a burst. The stimulus aims at this in two ways. First, it finishes a burst with a nonzero release window and raises a start with the opposite direction in the cycle just after the finish pulse. The old level must then hold for the whole window, and the new one must appear on the exact following edge. Second, it repeats the same move with zero setup and zero release, so the request hits the one cycle in which an immediate start pulse would join the finish pulse. The bench also drives a stop into the start-pulse cycle, and changes the mode in the middle of a burst, to show that both are deferred and not lost.

// File: rtl/bds_pkg.sv
package bds_pkg;
  typedef enum logic [1:0] {
    MODE_TDD   = 2'd0,
    MODE_FDD   = 2'd1,
    MODE_INDEP = 2'd2,
    MODE_ALT   = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_SETUP   = 2'd1,
    SQ_BURST   = 2'd2,
    SQ_RELEASE = 2'd3
  } seq_e;
endpackage

// File: rtl/bds_ctrl.sv
module bds_ctrl
  import bds_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_start_i,
  input  logic             req_dir_i,
  input  logic             req_stop_i,
  input  logic [CNT_W-1:0] setup_cyc_i,
  input  logic [CNT_W-1:0] release_cyc_i,
  output logic             enable_o,
  output logic             busy_o,
  output logic             burst_o,
  output logic             err_start_o,
  output logic             err_stop_o,
  output logic             dir_load_o,
  output logic             dir_val_o,
  output logic             idle_free_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_e             state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             en_q, en_n;
  logic             pend_q, pend_n;
  logic             pdir_q, pdir_n;
  logic             spend_q, spend_n;
  logic             es_q, es_n;
  logic             ep_q, ep_n;
  logic             zero_setup;

  assign zero_setup = (setup_cyc_i == '0);

  always_comb begin
    state_n     = state_q;
    cnt_n       = cnt_q;
    en_n        = 1'b0;
    pend_n      = pend_q;
    pdir_n      = pdir_q;
    spend_n     = spend_q;
    es_n        = es_q;
    ep_n        = ep_q;
    dir_load_o  = 1'b0;
    dir_val_o   = pend_q ? pdir_q : req_dir_i;
    idle_free_o = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (req_stop_i) ep_n = 1'b1;
        if (pend_q && req_start_i) es_n = 1'b1;
        if (pend_q || req_start_i) begin
          if (en_q && zero_setup) begin
            // back-to-back pulse would merge: park the request one cycle
            if (!pend_q) begin
              pend_n = 1'b1;
              pdir_n = req_dir_i;
            end
          end else begin
            dir_load_o = 1'b1;
            pend_n     = 1'b0;
            if (zero_setup) begin
              en_n    = 1'b1;
              state_n = SQ_BURST;
            end else begin
              cnt_n   = setup_cyc_i - ONE;
              state_n = SQ_SETUP;
            end
          end
        end else begin
          idle_free_o = 1'b1;
        end
      end
      SQ_SETUP: begin
        if (req_start_i) es_n = 1'b1;
        if (req_stop_i)  ep_n = 1'b1;
        if (cnt_q == '0) begin
          en_n    = 1'b1;
          state_n = SQ_BURST;
        end else begin
          cnt_n = cnt_q - ONE;
        end
      end
      SQ_BURST: begin
        if (req_start_i) es_n = 1'b1;
        if ((req_stop_i || spend_q) && !en_q) begin
          en_n    = 1'b1;
          spend_n = 1'b0;
          if (release_cyc_i == '0) begin
            state_n = SQ_IDLE;
          end else begin
            cnt_n   = release_cyc_i - ONE;
            state_n = SQ_RELEASE;
          end
        end else if (req_stop_i) begin
          spend_n = 1'b1;
        end
      end
      SQ_RELEASE: begin
        if (req_stop_i) ep_n = 1'b1;
        if (req_start_i) begin
          if (pend_q) begin
            es_n = 1'b1;
          end else begin
            pend_n = 1'b1;
            pdir_n = req_dir_i;
          end
        end
        if (cnt_q == '0) state_n = SQ_IDLE;
        else             cnt_n   = cnt_q - ONE;
      end
      default: state_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      pdir_q  <= 1'b0;
      spend_q <= 1'b0;
      es_q    <= 1'b0;
      ep_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      en_q    <= en_n;
      pend_q  <= pend_n;
      pdir_q  <= pdir_n;
      spend_q <= spend_n;
      es_q    <= es_n;
      ep_q    <= ep_n;
    end
  end

  assign enable_o    = en_q;
  assign busy_o      = (state_q == SQ_SETUP) || (state_q == SQ_BURST);
  assign burst_o     = (state_q == SQ_BURST);
  assign err_start_o = es_q;
  assign err_stop_o  = ep_q;
endmodule

// File: rtl/bds_dir.sv
module bds_dir
  import bds_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  dir_load_i,
  input  logic  dir_val_i,
  input  logic  tx_on_i,
  output logic  txnrx_o
);
  logic dir_q, dir_n;

  always_comb begin
    dir_n = dir_q;
    unique case (mode_i)
      MODE_TDD:   if (dir_load_i) dir_n = dir_val_i;
      MODE_INDEP: dir_n = tx_on_i;
      default:    dir_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dir_q <= 1'b0;
    else         dir_q <= dir_n;
  end

  assign txnrx_o = dir_q;
endmodule

// File: rtl/burst_dir_seq.sv
module burst_dir_seq
  import bds_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             req_start_i,
  input  logic             req_dir_i,
  input  logic             req_stop_i,
  input  logic             tx_on_i,
  input  logic [CNT_W-1:0] setup_cyc_i,
  input  logic [CNT_W-1:0] release_cyc_i,
  output logic             enable_o,
  output logic             txnrx_o,
  output logic             busy_o,
  output logic             burst_active_o,
  output logic             err_start_o,
  output logic             err_stop_o
);
  logic  rst_meta_q, rst_n_s;
  mode_e mode_q;
  logic  dir_load, dir_val, idle_free;

  // assert immediately, release after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n_s    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_s    <= rst_meta_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s)       mode_q <= MODE_TDD;
    else if (idle_free) mode_q <= mode_e'(mode_i);
  end

  bds_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .req_start_i  (req_start_i),
    .req_dir_i    (req_dir_i),
    .req_stop_i   (req_stop_i),
    .setup_cyc_i  (setup_cyc_i),
    .release_cyc_i(release_cyc_i),
    .enable_o     (enable_o),
    .busy_o       (busy_o),
    .burst_o      (burst_active_o),
    .err_start_o  (err_start_o),
    .err_stop_o   (err_stop_o),
    .dir_load_o   (dir_load),
    .dir_val_o    (dir_val),
    .idle_free_o  (idle_free)
  );

  bds_dir u_dir (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .mode_i    (mode_q),
    .dir_load_i(dir_load),
    .dir_val_i (dir_val),
    .tx_on_i   (tx_on_i),
    .txnrx_o   (txnrx_o)
  );
endmodule

// File: rtl/burst_dir_seq_chk.sv
module burst_dir_seq_chk
  import bds_pkg::*;
(
  input logic  clk_i,
  input logic  rst_n,
  input mode_e mode_q,
  input logic  tx_on_i,
  input logic  enable_o,
  input logic  txnrx_o,
  input logic  busy_o,
  input logic  burst_active_o,
  input logic  err_start_o,
  input logic  err_stop_o
);
  AST_DIR_HELD_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_n)
    (mode_q == MODE_TDD) && $past(burst_active_o) && burst_active_o |-> $stable(txnrx_o)); // R3

  AST_DIR_MOVES_IN_ALERT: assert property (@(posedge clk_i) disable iff (!rst_n)
    (txnrx_o != $past(txnrx_o)) && ($past(mode_q) == MODE_TDD) |-> !$past(burst_active_o)); // R3

  AST_START_PULSE_OPENS: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(burst_active_o) |-> enable_o); // R6

  AST_FINISH_PULSE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(burst_active_o) |-> enable_o); // R4

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    enable_o |=> !enable_o); // R12

  AST_ERR_START_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_start_o |=> err_start_o); // R7

  AST_ERR_STOP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_stop_o |=> err_stop_o); // R8

  AST_FDD_PARKED_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(mode_q) == MODE_FDD) || ($past(mode_q) == MODE_ALT) |-> !txnrx_o); // R9

  AST_TXON_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(mode_q) == MODE_INDEP) |-> (txnrx_o == $past(tx_on_i))); // R10

  AST_MODE_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(mode_q)); // R11
endmodule

bind burst_dir_seq burst_dir_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_n         (rst_n_s),
  .mode_q        (mode_q),
  .tx_on_i       (tx_on_i),
  .enable_o      (enable_o),
  .txnrx_o       (txnrx_o),
  .busy_o        (busy_o),
  .burst_active_o(burst_active_o),
  .err_start_o   (err_start_o),
  .err_stop_o    (err_stop_o)
);

// File: tb/test_burst_dir_seq.sv
module test_burst_dir_seq;
  localparam int CW = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic [1:0]    mode_i;
  logic          req_start_i, req_dir_i, req_stop_i, tx_on_i;
  logic [CW-1:0] setup_cyc_i, release_cyc_i;
  logic          enable_o, txnrx_o, busy_o, burst_active_o, err_start_o, err_stop_o;
  int            n_chk = 0;
  int            n_bad = 0;

  // {mode[2], dir, tx_on, setup[4], release[4], burst length[4], expected txnrx}
  localparam logic [16:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b0, 4'd0, 4'd0, 4'd2, 1'b1},
    {2'd0, 1'b0, 1'b0, 4'd3, 4'd1, 4'd1, 1'b0},
    {2'd0, 1'b1, 1'b0, 4'd5, 4'd2, 4'd4, 1'b1},
    {2'd1, 1'b1, 1'b0, 4'd2, 4'd0, 4'd2, 1'b0},
    {2'd2, 1'b0, 1'b1, 4'd1, 4'd0, 4'd3, 1'b1},
    {2'd2, 1'b1, 1'b0, 4'd0, 4'd3, 4'd1, 1'b0},
    {2'd0, 1'b0, 1'b0, 4'd1, 4'd0, 4'd2, 1'b0},
    {2'd3, 1'b1, 1'b0, 4'd0, 4'd0, 4'd1, 1'b0}
  };

  always #5 clk_i = ~clk_i;

  burst_dir_seq #(.CNT_W(CW)) i_burst_dir_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .req_start_i(req_start_i), .req_dir_i(req_dir_i), .req_stop_i(req_stop_i),
    .tx_on_i(tx_on_i), .setup_cyc_i(setup_cyc_i), .release_cyc_i(release_cyc_i),
    .enable_o(enable_o), .txnrx_o(txnrx_o), .busy_o(busy_o),
    .burst_active_o(burst_active_o), .err_start_o(err_start_o), .err_stop_o(err_stop_o)
  );

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick(); tick();
    rst_ni = 1'b1;
    repeat (3) tick();
  endtask

  task automatic run_vec(input logic [16:0] v);
    int k;
    mode_i = v[16:15]; tx_on_i = v[13];
    setup_cyc_i = v[12:9]; release_cyc_i = v[8:5];
    repeat (3) tick();
    req_start_i = 1'b1; req_dir_i = v[14];
    tick();
    req_start_i = 1'b0;
    chk("R2 R9 R10 txnrx after accept", txnrx_o, v[0]);
    chk("R6 busy after accept", busy_o, 1);
    k = 0;
    while (!enable_o && k < 20) begin tick(); k++; end
    chk("R2 setup cycles to start pulse", k, v[12:9]);
    chk("R2 txnrx at start pulse", txnrx_o, v[0]);
    chk("R6 burst_active at start pulse", burst_active_o, 1);
    for (int i = 0; i < int'(v[4:1]); i++) begin
      tick();
      chk("R3 txnrx held in burst", txnrx_o, v[0]);
      chk("R6 busy in burst", busy_o, 1);
    end
    req_stop_i = 1'b1;
    tick();
    req_stop_i = 1'b0;
    chk("R4 finish pulse", enable_o, 1);
    chk("R6 busy at finish", busy_o, 0);
    repeat (int'(v[8:5]) + 2) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    mode_i = 2'd0; req_start_i = 0; req_dir_i = 0; req_stop_i = 0; tx_on_i = 0;
    setup_cyc_i = '0; release_cyc_i = '0;
    do_reset();
    // R1 reset state
    chk("R1 enable", enable_o, 0);
    chk("R1 txnrx", txnrx_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 burst_active", burst_active_o, 0);
    chk("R1 err_start", err_start_o, 0);
    chk("R1 err_stop", err_stop_o, 0);

    for (int v = 0; v < 8; v++) run_vec(VEC[v]);

    // R7: start during setup and during burst
    do_reset();
    mode_i = 2'd0; setup_cyc_i = 4'd2; release_cyc_i = 4'd0;
    tick();
    req_start_i = 1; req_dir_i = 1; tick();
    req_start_i = 1; req_dir_i = 0; tick(); req_start_i = 0;
    chk("R7 err_start after start in setup", err_start_o, 1);
    chk("R7 txnrx unchanged", txnrx_o, 1);
    tick();
    chk("R7 start pulse still issued", enable_o, 1);
    tick();
    req_start_i = 1; tick(); req_start_i = 0;
    chk("R7 burst continues", burst_active_o, 1);
    chk("R7 txnrx kept", txnrx_o, 1);
    req_stop_i = 1; tick(); req_stop_i = 0;
    tick(); tick();
    // R8: stop while idle
    req_stop_i = 1; tick(); req_stop_i = 0;
    chk("R8 err_stop set", err_stop_o, 1);
    chk("R8 no pulse", enable_o, 0);
    tick();
    chk("R7 err_start sticky", err_start_o, 1);
    chk("R8 err_stop sticky", err_stop_o, 1);

    // R4: stop in start-pulse cycle is deferred one cycle
    do_reset();
    setup_cyc_i = 4'd0; release_cyc_i = 4'd0;
    req_start_i = 1; req_dir_i = 1; tick(); req_start_i = 0;
    req_stop_i = 1; tick(); req_stop_i = 0;
    chk("R4 stop deferred", enable_o, 0);
    chk("R4 burst still active", burst_active_o, 1);
    tick();
    chk("R4 deferred finish pulse", enable_o, 1);
    chk("R6 burst_active falls with finish", burst_active_o, 0);
    tick(); tick();

    // R5: start inside release window waits for window end
    release_cyc_i = 4'd3;
    req_start_i = 1; req_dir_i = 1; tick(); req_start_i = 0;
    tick();
    req_stop_i = 1; tick(); req_stop_i = 0;
    req_start_i = 1; req_dir_i = 0; tick(); req_start_i = 0;
    chk("R5 release hold 1", txnrx_o, 1);
    tick();
    chk("R5 release hold 2", txnrx_o, 1);
    tick();
    chk("R5 release hold 3", txnrx_o, 1);
    tick();
    chk("R5 held start served", txnrx_o, 0);
    chk("R5 held start pulse", enable_o, 1);
    tick();
    req_stop_i = 1; tick(); req_stop_i = 0;
    repeat (5) tick();

    // R12: zero setup, start in finish-pulse cycle
    release_cyc_i = 4'd0;
    req_start_i = 1; req_dir_i = 1; tick(); req_start_i = 0;
    tick();
    req_stop_i = 1; tick(); req_stop_i = 0;
    req_start_i = 1; req_dir_i = 0; tick(); req_start_i = 0;
    chk("R12 no back-to-back pulse", enable_o, 0);
    chk("R12 txnrx not yet moved", txnrx_o, 1);
    tick();
    chk("R12 delayed start pulse", enable_o, 1);
    chk("R12 new direction", txnrx_o, 0);
    tick();
    req_stop_i = 1; tick(); req_stop_i = 0;
    tick(); tick();

    // R11: mode change during burst deferred
    req_start_i = 1; req_dir_i = 0; tick(); req_start_i = 0;
    mode_i = 2'd2; tx_on_i = 1;
    repeat (3) tick();
    chk("R11 mode held during burst", txnrx_o, 0);
    req_stop_i = 1; tick(); req_stop_i = 0;
    repeat (3) tick();
    chk("R11 mode applied after burst", txnrx_o, 1);

    // R10: transmit-on follows input during a burst
    req_start_i = 1; req_dir_i = 0; tick(); req_start_i = 0;
    tick();
    tx_on_i = 0; tick();
    chk("R10 tx_on low followed", txnrx_o, 0);
    chk("R10 burst running", burst_active_o, 1);
    tx_on_i = 1; tick();
    chk("R10 tx_on high followed", txnrx_o, 1);
    req_stop_i = 1; tick(); req_stop_i = 0;
    tick(); tick();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule